// File: doc/BRIEF.md
# Translation Buffer Fill and Invalidate Controller

This block holds a small, fully associative translation buffer shared by the instruction side and the data side. Each entry carries a side bit and a virtual tag. It also carries a physical page number, a four-bit read enable mask and a four-bit write enable mask, two fault bits (fault on read, fault on write), a global bit that makes the entry match under any address-space number, and the address-space number (ASN) it was installed under. Software never writes an entry in one step. It writes a sequence of control registers, and the last write of the sequence commits the entry. The data side stages the page table entry (PTE) first and commits on the tag write. The instruction side latches the tag first and commits on the PTE write. Three invalidate commands per side remove every entry, only the non-global entries, or the one entry for a given address.

A combinational lookup port takes a side and a tag and returns a hit flag and the matching entry packed back into PTE layout. Control writes are accepted on a single write port while `ready` is high.

A small state machine sequences the work. It has three states:

- `ST_IDLE` accepts writes and may stay in `ST_IDLE`.
- After a fill is accepted, the transition to `ST_INSERT` places the pending entry. `ST_INSERT` then returns to `ST_IDLE` after one cycle.
- After an invalidate is accepted, the transition to `ST_SWEEP` visits one entry per cycle. `ST_SWEEP` returns to `ST_IDLE` after the last entry.

Top module: `tlbf_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `fill_err` is 0 and every lookup misses. A miss always returns `lk_pte` equal to 0.
- R2: The data fill works in two writes. A write to select 2 stages a PTE. A later write to select 3 inserts an entry whose tag is `wr_data[TAG_W-1:0]`, whose fields come from the staged PTE, and whose ASN is the data ASN current at that write. Select 0 sets the data ASN from `wr_data[6:0]`.
- R3: The instruction fill works in two writes. A write to select 4 latches the tag. A later write to select 5 inserts an entry built from that write's PTE and the instruction ASN current at that write. Select 1 sets the instruction ASN from `wr_data[6:0]`.
- R4: An instruction entry always reads back with its write enable mask equal to 0, whatever the written PTE holds.
- R5: When the granularity field `wr_data[6:5]` of the PTE used by a fill is nonzero, no entry is inserted. `fill_err` is then high for one cycle after the commit write. The block stays ready.
- R6: A lookup hits only when all of these hold: the entry is valid, the side matches, the tag matches, and either the entry ASN equals the current ASN of that side or the entry is global.
- R7: Invalidate-process removes only the non-global entries of its side. It is select 7 for data and select 10 for instruction.
- R8: Invalidate-single removes the entry of its side whose tag equals `wr_data[TAG_W-1:0]` and that is either global or carries the current ASN of that side. It is select 8 for data and select 11 for instruction.
- R9: Invalidate-all removes every entry of its side and leaves the other side untouched. It is select 6 for data and select 9 for instruction.
- R10: A fill takes the lowest-numbered invalid entry. When every entry is valid, a fill replaces entries in round-robin order starting from entry 0.
- R11: `ready` drops for exactly 1 cycle after an accepted fill commit and for exactly ENTRIES cycles after an accepted invalidate. It stays high after a register-only write.
- R12: The PTE layout is the same for writes and for `lk_pte`, with these field positions:
  - page number: 27 bits at bit 32
  - read enables: bits 11:8
  - write enables: bits 15:12
  - fault-on-read: bit 1
  - fault-on-write: bit 2
  - global: bit 4
  - ASN: 7 bits at bit 57 (readback only, ORed over the page number)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control write strobe, taken when ready is high |
| wr_sel | input | 4 | Control register select |
| wr_data | input | 64 | Control write data |
| ready | output | 1 | High in ST_IDLE, when writes are accepted |
| fill_err | output | 1 | One-cycle pulse for a rejected fill |
| lk_side | input | 1 | Lookup side: 0 data, 1 instruction |
| lk_tag | input | TAG_W | Lookup tag |
| lk_hit | output | 1 | Lookup hit |
| lk_pte | output | 64 | Packed PTE of the hit entry, 0 on a miss |

## Verification
The bench builds the block with ENTRIES set to 4 and TAG_W left at 32. Four entries let a short sequence fill the whole buffer. The buffer therefore reaches the round-robin replacement path after four fills, and the busy time of an invalidate sweep is a small number that the bench checks exactly. Fills on both sides share the buffer. This mixing lets the bench show that side-scoped invalidates leave the other side intact and that global entries survive both an ASN change and an invalidate-process.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    localparam int PTE_W    = 64;
    localparam int PPN_W    = 27;
    localparam int ASN_W    = 7;
    localparam int MASK_W   = 4;
    localparam int PPN_LO   = 32;
    localparam int RDE_LO   = 8;
    localparam int WRE_LO   = 12;
    localparam int FRD_BIT  = 1;
    localparam int FWR_BIT  = 2;
    localparam int GLOB_BIT = 4;
    localparam int ASN_LO   = 57;
    localparam int GH_LO    = 5;
    localparam int GH_W     = 2;

    typedef enum logic [3:0] {
        REG_D_ASN      = 4'd0,
        REG_I_ASN      = 4'd1,
        REG_D_PTE      = 4'd2,
        REG_D_TAG      = 4'd3,
        REG_I_TAG      = 4'd4,
        REG_I_PTE      = 4'd5,
        REG_D_INV_ALL  = 4'd6,
        REG_D_INV_PROC = 4'd7,
        REG_D_INV_ONE  = 4'd8,
        REG_I_INV_ALL  = 4'd9,
        REG_I_INV_PROC = 4'd10,
        REG_I_INV_ONE  = 4'd11
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INSERT = 2'd1,
        ST_SWEEP  = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        KILL_ALL   = 2'd0,
        KILL_LOCAL = 2'd1,
        KILL_ONE   = 2'd2
    } kill_mode_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [MASK_W-1:0] rd_en;
        logic [MASK_W-1:0] wr_en;
        logic              f_rd;
        logic              f_wr;
        logic              glob;
        logic [ASN_W-1:0]  asn;
    } pte_fields_t;

    function automatic pte_fields_t pte_unpack(input logic [PTE_W-1:0] d);
        pte_fields_t f;
        f.ppn   = d[PPN_LO +: PPN_W];
        f.rd_en = d[RDE_LO +: MASK_W];
        f.wr_en = d[WRE_LO +: MASK_W];
        f.f_rd  = d[FRD_BIT];
        f.f_wr  = d[FWR_BIT];
        f.glob  = d[GLOB_BIT];
        f.asn   = '0;
        return f;
    endfunction

    function automatic logic pte_gh_bad(input logic [PTE_W-1:0] d);
        return d[GH_LO +: GH_W] != '0;
    endfunction

endpackage

// File: rtl/tlbf_pack.sv
module tlbf_pack
    import tlbf_pkg::*;
(
    input  pte_fields_t      f_i,
    input  logic             hit_i,
    output logic [PTE_W-1:0] pte_o
);
    logic [PTE_W-1:0] packed_w;

    always_comb begin
        packed_w = '0;
        packed_w = packed_w | (PTE_W'(f_i.ppn)   << PPN_LO);
        packed_w = packed_w | (PTE_W'(f_i.rd_en) << RDE_LO);
        packed_w = packed_w | (PTE_W'(f_i.wr_en) << WRE_LO);
        packed_w = packed_w | (PTE_W'(f_i.asn)   << ASN_LO);
        packed_w[FRD_BIT]  = f_i.f_rd;
        packed_w[FWR_BIT]  = f_i.f_wr;
        packed_w[GLOB_BIT] = f_i.glob;
        pte_o = hit_i ? packed_w : '0;
    end
endmodule

// File: rtl/tlbf_victim.sv
module tlbf_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               adv_i,
    output logic [IDX_W-1:0]   pick_o,
    output logic               full_o
);
    logic [IDX_W-1:0] rr_q;

    always_comb begin
        full_o = &valid_i;
        pick_o = rr_q;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) pick_o = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (adv_i) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlbf_store.sv
module tlbf_store
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_en_i,
    input  logic [IDX_W-1:0]   ins_idx_i,
    input  logic               ins_side_i,
    input  logic [TAG_W-1:0]   ins_tag_i,
    input  pte_fields_t        ins_f_i,
    input  logic               clr_en_i,
    input  logic [IDX_W-1:0]   sel_idx_i,
    output logic               sel_valid_o,
    output logic               sel_side_o,
    output logic [TAG_W-1:0]   sel_tag_o,
    output pte_fields_t        sel_f_o,
    output logic [ENTRIES-1:0] valid_o,
    input  logic               lk_side_i,
    input  logic [TAG_W-1:0]   lk_tag_i,
    input  logic [ASN_W-1:0]   lk_asn_i,
    output logic               lk_hit_o,
    output pte_fields_t        lk_f_o
);
    logic [ENTRIES-1:0]             hit_vec;
    logic [ENTRIES-1:0]             side_vec;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_vec;
    pte_fields_t [ENTRIES-1:0]      f_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic             v_q;
        logic             s_q;
        logic [TAG_W-1:0] t_q;
        pte_fields_t      f_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (ins_en_i && ins_idx_i == IDX_W'(g)) begin
                v_q <= 1'b1;
            end else if (clr_en_i && sel_idx_i == IDX_W'(g)) begin
                v_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (ins_en_i && ins_idx_i == IDX_W'(g)) begin
                s_q <= ins_side_i;
                t_q <= ins_tag_i;
                f_q <= ins_f_i;
            end
        end

        assign valid_o[g]  = v_q;
        assign side_vec[g] = s_q;
        assign tag_vec[g]  = t_q;
        assign f_vec[g]    = f_q;
        assign hit_vec[g]  = v_q && (s_q == lk_side_i) && (t_q == lk_tag_i)
                             && (f_q.glob || f_q.asn == lk_asn_i);
    end

    always_comb begin
        lk_f_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) lk_f_o = f_vec[i];
        end
        lk_hit_o = |hit_vec;
    end

    assign sel_valid_o = valid_o[sel_idx_i];
    assign sel_side_o  = side_vec[sel_idx_i];
    assign sel_tag_o   = tag_vec[sel_idx_i];
    assign sel_f_o     = f_vec[sel_idx_i];
endmodule

// File: rtl/tlbf_ctrl.sv
module tlbf_ctrl
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [63:0]       wr_data,
    output logic              ready,
    output logic              fill_err,
    input  logic              lk_side,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [63:0]       lk_pte
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    ctl_state_e        state_q, state_d;
    logic [IDX_W-1:0]  sweep_q;
    kill_mode_e        kmode_q;
    logic              kside_q;
    logic [TAG_W-1:0]  ktag_q;
    logic [ASN_W-1:0]  kasn_q;
    logic [ASN_W-1:0]  d_asn_q, i_asn_q;
    logic [PTE_W-1:0]  d_pte_q;
    logic [TAG_W-1:0]  i_tag_q;
    logic              pend_side_q;
    logic [TAG_W-1:0]  pend_tag_q;
    pte_fields_t       pend_f_q;
    logic              err_q;

    logic              accept;
    logic              fill_ok, fill_bad, is_inv;
    logic              ins_en, clr_en, victim_adv, full;
    logic [IDX_W-1:0]  victim;
    logic              sel_valid, sel_side;
    logic [TAG_W-1:0]  sel_tag;
    pte_fields_t       sel_f, lk_f, d_fields, i_fields;
    logic [ENTRIES-1:0] valid_vec;
    logic [ASN_W-1:0]  lk_asn;
    reg_sel_e          sel;

    assign sel    = reg_sel_e'(wr_sel);
    assign accept = wr_en && (state_q == ST_IDLE);

    always_comb begin
        d_fields       = pte_unpack(d_pte_q);
        d_fields.asn   = d_asn_q;
        i_fields       = pte_unpack(wr_data);
        i_fields.wr_en = '0;
        i_fields.asn   = i_asn_q;
    end

    always_comb begin
        fill_ok  = 1'b0;
        fill_bad = 1'b0;
        is_inv   = 1'b0;
        unique case (sel)
            REG_D_TAG: begin
                fill_bad = pte_gh_bad(d_pte_q);
                fill_ok  = !fill_bad;
            end
            REG_I_PTE: begin
                fill_bad = pte_gh_bad(wr_data);
                fill_ok  = !fill_bad;
            end
            REG_D_INV_ALL, REG_D_INV_PROC, REG_D_INV_ONE,
            REG_I_INV_ALL, REG_I_INV_PROC, REG_I_INV_ONE: is_inv = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && fill_ok)     state_d = ST_INSERT;
                else if (accept && is_inv) state_d = ST_SWEEP;
            end
            ST_INSERT: state_d = ST_IDLE;
            ST_SWEEP:  if (sweep_q == LAST_IDX) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_asn_q     <= '0;
            i_asn_q     <= '0;
            d_pte_q     <= '0;
            i_tag_q     <= '0;
            sweep_q     <= '0;
            kmode_q     <= KILL_ALL;
            kside_q     <= 1'b0;
            ktag_q      <= '0;
            kasn_q      <= '0;
            pend_side_q <= 1'b0;
            pend_tag_q  <= '0;
            pend_f_q    <= '0;
            err_q       <= 1'b0;
        end else begin
            err_q <= accept && fill_bad;
            if (state_q == ST_SWEEP) sweep_q <= sweep_q + 1'b1;
            if (accept) begin
                unique case (sel)
                    REG_D_ASN: d_asn_q <= wr_data[ASN_W-1:0];
                    REG_I_ASN: i_asn_q <= wr_data[ASN_W-1:0];
                    REG_D_PTE: d_pte_q <= wr_data;
                    REG_I_TAG: i_tag_q <= wr_data[TAG_W-1:0];
                    REG_D_TAG: begin
                        pend_side_q <= 1'b0;
                        pend_tag_q  <= wr_data[TAG_W-1:0];
                        pend_f_q    <= d_fields;
                    end
                    REG_I_PTE: begin
                        pend_side_q <= 1'b1;
                        pend_tag_q  <= i_tag_q;
                        pend_f_q    <= i_fields;
                    end
                    REG_D_INV_ALL, REG_D_INV_PROC, REG_D_INV_ONE: begin
                        sweep_q <= '0;
                        kside_q <= 1'b0;
                        ktag_q  <= wr_data[TAG_W-1:0];
                        kasn_q  <= d_asn_q;
                        kmode_q <= (sel == REG_D_INV_ALL)  ? KILL_ALL :
                                   (sel == REG_D_INV_PROC) ? KILL_LOCAL : KILL_ONE;
                    end
                    REG_I_INV_ALL, REG_I_INV_PROC, REG_I_INV_ONE: begin
                        sweep_q <= '0;
                        kside_q <= 1'b1;
                        ktag_q  <= wr_data[TAG_W-1:0];
                        kasn_q  <= i_asn_q;
                        kmode_q <= (sel == REG_I_INV_ALL)  ? KILL_ALL :
                                   (sel == REG_I_INV_PROC) ? KILL_LOCAL : KILL_ONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ready      = (state_q == ST_IDLE);
        fill_err   = err_q;
        ins_en     = (state_q == ST_INSERT);
        victim_adv = ins_en && full;
        clr_en     = 1'b0;
        if (state_q == ST_SWEEP && sel_valid && sel_side == kside_q) begin
            unique case (kmode_q)
                KILL_ALL:   clr_en = 1'b1;
                KILL_LOCAL: clr_en = !sel_f.glob;
                KILL_ONE:   clr_en = (sel_tag == ktag_q) &&
                                     (sel_f.glob || sel_f.asn == kasn_q);
                default:    clr_en = 1'b0;
            endcase
        end
    end

    assign lk_asn = lk_side ? i_asn_q : d_asn_q;

    tlbf_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_vec),
        .adv_i   (victim_adv),
        .pick_o  (victim),
        .full_o  (full)
    );

    tlbf_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_en_i    (ins_en),
        .ins_idx_i   (victim),
        .ins_side_i  (pend_side_q),
        .ins_tag_i   (pend_tag_q),
        .ins_f_i     (pend_f_q),
        .clr_en_i    (clr_en),
        .sel_idx_i   (sweep_q),
        .sel_valid_o (sel_valid),
        .sel_side_o  (sel_side),
        .sel_tag_o   (sel_tag),
        .sel_f_o     (sel_f),
        .valid_o     (valid_vec),
        .lk_side_i   (lk_side),
        .lk_tag_i    (lk_tag),
        .lk_asn_i    (lk_asn),
        .lk_hit_o    (lk_hit),
        .lk_f_o      (lk_f)
    );

    tlbf_pack u_pack (
        .f_i   (lk_f),
        .hit_i (lk_hit),
        .pte_o (lk_pte)
    );
endmodule

// File: rtl/tlbf_ctrl_chk.sv
module tlbf_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_sel,
    input logic [63:0] wr_data,
    input logic        ready,
    input logic        fill_err,
    input logic        lk_side,
    input logic        lk_hit,
    input logic [63:0] lk_pte,
    input logic        in_insert
);
    logic take_ipte, take_inv;
    assign take_ipte = wr_en && ready && wr_sel == 4'd5;
    assign take_inv  = wr_en && ready && wr_sel >= 4'd6 && wr_sel <= 4'd11;

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_pte == 64'd0); // R1

    AST_INSTR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_side) |-> lk_pte[15:12] == 4'd0); // R4

    AST_REJECT_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ipte && wr_data[6:5] != 2'd0) |=> (fill_err && ready)); // R5

    AST_FILL_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ipte && wr_data[6:5] == 2'd0) |=> (!ready && !fill_err)); // R11

    AST_INSERT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_insert |=> ready); // R11

    AST_SWEEP_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take_inv |=> !ready); // R11
endmodule

bind tlbf_ctrl tlbf_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ready     (ready),
    .fill_err  (fill_err),
    .lk_side   (lk_side),
    .lk_hit    (lk_hit),
    .lk_pte    (lk_pte),
    .in_insert (state_q == tlbf_pkg::ST_INSERT)
);

// File: tb/sim_tlbf_ctrl.sv
`timescale 1ns/1ps
module sim_tlbf_ctrl;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic        ready, fill_err;
    logic        lk_side = 1'b0;
    logic [31:0] lk_tag = '0;
    logic        lk_hit;
    logic [63:0] lk_pte;

    int checks = 0;
    int fails = 0;
    int busy = 0;
    logic err_seen;

    typedef struct {
        bit          side;
        logic [31:0] tag;
        bit          hit;
        logic [63:0] pte;
        string       req;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    tlbf_ctrl #(.ENTRIES(N), .TAG_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ready(ready), .fill_err(fill_err),
        .lk_side(lk_side), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_pte(lk_pte)
    );

    function automatic logic [63:0] mk(input logic [26:0] ppn, input logic [3:0] rd,
        input logic [3:0] wr, input bit fr, input bit fw, input bit g,
        input logic [6:0] asn, input logic [1:0] gh);
        logic [63:0] v;
        v = (64'(ppn) << 32) | (64'(rd) << 8) | (64'(wr) << 12) | (64'(asn) << 57);
        v[1] = fr; v[2] = fw; v[4] = g; v[6:5] = gh;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        err_seen = fill_err;
        busy = 0;
        while (!ready) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic look(input bit side, input logic [31:0] tag, input bit hit,
                        input logic [63:0] pte, input string req);
        item_t it;
        it.side = side; it.tag = tag; it.hit = hit; it.pte = pte; it.req = req;
        q.push_back(it);
        wait (q.size() == 0);
        #2;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q[0];
                lk_side = it.side;
                lk_tag  = it.tag;
                #1;
                check(lk_hit == it.hit, {it.req, " hit"}, 64'(lk_hit), 64'(it.hit));
                check(lk_pte == it.pte, {it.req, " pte"}, lk_pte, it.pte);
                void'(q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        finish_run();
    end

    initial begin : driver
        logic [63:0] pd, pi, pg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ready == 1'b1, "R1 ready", 64'(ready), 64'd1);
        check(fill_err == 1'b0, "R1 fill_err", 64'(fill_err), 64'd0);
        look(0, 32'h5, 0, 64'd0, "R1 empty");

        // R2: data fill, PTE staged then tag
        pd = mk(27'h123, 4'hA, 4'h5, 1, 0, 0, 0, 0);
        wr(4'd0, 64'd3);
        check(busy == 0, "R11 reg write busy", 64'(busy), 64'd0);
        wr(4'd2, pd);
        look(0, 32'h40, 0, 64'd0, "R2 staged only");
        wr(4'd3, 64'h40);
        check(busy == 1, "R11 fill busy", 64'(busy), 64'd1);
        look(0, 32'h40, 1, mk(27'h123, 4'hA, 4'h5, 1, 0, 0, 7'd3, 0), "R2 R12 data entry");
        look(1, 32'h40, 0, 64'd0, "R6 side mismatch");

        // R3/R4: instruction fill, tag then PTE, write enables dropped
        pi = mk(27'h7ABCD, 4'h3, 4'hF, 0, 1, 1, 0, 0);
        wr(4'd1, 64'd9);
        wr(4'd4, 64'h80);
        look(1, 32'h80, 0, 64'd0, "R3 tag only");
        wr(4'd5, pi);
        look(1, 32'h80, 1, mk(27'h7ABCD, 4'h3, 4'h0, 0, 1, 1, 7'd9, 0), "R3 R4 instr entry");

        // R6: ASN match rule
        wr(4'd0, 64'd4);
        look(0, 32'h40, 0, 64'd0, "R6 asn mismatch");
        wr(4'd1, 64'd10);
        look(1, 32'h80, 1, mk(27'h7ABCD, 4'h3, 4'h0, 0, 1, 1, 7'd9, 0), "R6 global");

        // R5: granularity field rejects
        wr(4'd2, mk(27'h55, 4'h1, 4'h1, 0, 0, 0, 0, 2'd1));
        wr(4'd3, 64'h41);
        check(err_seen == 1'b1, "R5 data reject err", 64'(err_seen), 64'd1);
        check(busy == 0, "R5 stays ready", 64'(busy), 64'd0);
        look(0, 32'h41, 0, 64'd0, "R5 no entry");
        wr(4'd4, 64'h81);
        wr(4'd5, mk(27'h66, 4'h1, 4'h0, 0, 0, 0, 0, 2'd2));
        check(err_seen == 1'b1, "R5 instr reject err", 64'(err_seen), 64'd1);
        look(1, 32'h81, 0, 64'd0, "R5 no instr entry");

        // R7: invalidate-process keeps globals and other side
        pg = mk(27'h222, 4'h1, 4'h2, 0, 0, 1, 0, 0);
        wr(4'd2, mk(27'h111, 4'h1, 4'h2, 0, 0, 0, 0, 0));
        wr(4'd3, 64'h50);
        wr(4'd2, pg);
        wr(4'd3, 64'h51);
        wr(4'd7, 64'd0);
        check(busy == N, "R11 sweep busy", 64'(busy), 64'(N));
        look(0, 32'h50, 0, 64'd0, "R7 local removed");
        look(0, 32'h51, 1, mk(27'h222, 4'h1, 4'h2, 0, 0, 1, 7'd4, 0), "R7 global kept");
        look(1, 32'h80, 1, mk(27'h7ABCD, 4'h3, 4'h0, 0, 1, 1, 7'd9, 0), "R7 other side");

        // R8: invalidate-single honours ASN
        wr(4'd2, mk(27'h333, 4'h4, 4'h4, 1, 1, 0, 0, 0));
        wr(4'd3, 64'h60);
        wr(4'd0, 64'd5);
        wr(4'd8, 64'h60);
        wr(4'd0, 64'd4);
        look(0, 32'h60, 1, mk(27'h333, 4'h4, 4'h4, 1, 1, 0, 7'd4, 0), "R8 asn differs kept");
        wr(4'd8, 64'h60);
        look(0, 32'h60, 0, 64'd0, "R8 removed");

        // R9: invalidate-all of one side
        wr(4'd9, 64'd0);
        look(1, 32'h80, 0, 64'd0, "R9 instr cleared");
        look(0, 32'h51, 1, mk(27'h222, 4'h1, 4'h2, 0, 0, 1, 7'd4, 0), "R9 data kept");
        wr(4'd0, 64'd5);
        wr(4'd8, 64'h51);
        wr(4'd0, 64'd4);
        look(0, 32'h51, 0, 64'd0, "R8 global single removed");

        // R10: lowest free, then round robin
        wr(4'd6, 64'd0);
        for (int k = 0; k < N + 2; k++) begin
            wr(4'd2, mk(27'(k + 1), 4'h1, 4'h1, 0, 0, 0, 0, 0));
            wr(4'd3, 64'(32'h100 + k));
        end
        look(0, 32'h100, 0, 64'd0, "R10 first victim");
        look(0, 32'h101, 0, 64'd0, "R10 second victim");
        look(0, 32'h102, 1, mk(27'd3, 4'h1, 4'h1, 0, 0, 0, 7'd4, 0), "R10 kept");
        look(0, 32'(32'h100 + N), 1, mk(27'(N + 1), 4'h1, 4'h1, 0, 0, 0, 7'd4, 0), "R10 new");
        look(0, 32'(32'h101 + N), 1, mk(27'(N + 2), 4'h1, 4'h1, 0, 0, 0, 7'd4, 0), "R10 newer");

        finish_run();
    end
endmodule